// File: doc/BRIEF.md
# Flash Sector Map and Access Guard

This block sits beside the command path of a 512 KiB flash array. It turns a 19-bit byte address into the index of the erase sector that holds it. The array has eleven sectors of four different sizes. A parameter selects whether the small boot sector sits at the bottom or at the top of the address space. Sector indices always count upward with the address.

The block keeps a protect bit for each sector and a mask of the sectors chosen for the next multi-sector erase. It also keeps the set of sectors whose erase is still pending. Each request (read, program, sector erase or chip erase) is answered one cycle later. The answer is a single permit or reject pulse together with the sector index. An accepted erase also returns the set of sectors that will actually be erased.

A level input lifts all protection while it is held. A second level input marks the pending erase as suspended. While suspended, the array can be read and programmed outside the pending set.

Top module: `flash_sector_guard`

## Requirements
- R1: With `TOP_BOOT=0`, sector index 0 is the 16 KiB range at address 0. Index 1 starts at 0x04000 and index 2 at 0x06000, both 8 KiB. Index 3 starts at 0x08000 and is 32 KiB. Indices 4 to 10 are the 64 KiB ranges starting at 0x10000, 0x20000, and so on.
- R2: With `TOP_BOOT=1`, the order of sector sizes is mirrored. Indices 0 to 6 are the 64 KiB ranges from address 0. Index 7 starts at 0x70000 and is 32 KiB. Index 8 starts at 0x78000 and index 9 at 0x7A000, both 8 KiB. Index 10 covers 0x7C000 to 0x7FFFF.
- R3: A program request (`req_op`=1) to a sector whose protect bit is 1 is rejected while `tmp_unprot` is 0.
- R4: A sector erase (`req_op`=2) erases the selection mask minus the protected sectors. Bit i of `erase_set` stands for sector i. If nothing is left after removing protected sectors, the erase is rejected.
- R5: While `tmp_unprot` is 1, every protect bit is treated as 0. When it returns to 0, the stored protect bits apply again unchanged.
- R6: A chip erase (`req_op`=3) erases all eleven sectors minus the protected ones.
- R7: While an erase is pending, the response depends on `erase_susp`. With `erase_susp`=0, read (`req_op`=0) and program requests are rejected. With `erase_susp`=1, they are rejected only for sectors in the pending set and are otherwise judged normally.
- R8: A request answers in the next cycle with exactly one of `permit` or `reject` high for one cycle, and `sec_idx` holding its sector. No request means neither pulse.
- R9: Reset clears the protect bits, the selection mask and the pending erase set.
- R10: A protect-bit write and a request in the same cycle are judged against the protect value held before that write.
- R11: An erase request while an erase is pending is rejected. `erase_done` clears the pending set.
- R12: An accepted erase clears the selection mask. A later sector erase with no new selection is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| req_addr | input | 19 | Byte address of the request |
| prot_we | input | 1 | Protect bit write strobe |
| prot_idx | input | 4 | Sector to write; values above 10 are ignored |
| prot_val | input | 1 | New protect bit |
| sel_we | input | 1 | Erase selection write strobe |
| sel_idx | input | 4 | Sector to select; values above 10 are ignored |
| sel_val | input | 1 | New selection bit |
| tmp_unprot | input | 1 | Temporary override of all protection |
| erase_susp | input | 1 | Pending erase is suspended |
| erase_done | input | 1 | Pending erase finished |
| sec_idx | output | 4 | Sector of the last request |
| permit | output | 1 | Request accepted pulse |
| reject | output | 1 | Request refused pulse |
| erase_set | output | 11 | Sectors taken by an accepted erase, else zero |

## Verification
Two functions can meet in one cycle: a protect-bit update and a program request aimed at the same sector. The bench drives both on the same edge in both directions, setting the bit and clearing it. It expects the first answer to follow the old bit and the very next request to follow the new one. Chip erase under a mix of protected sectors is then combined with suspend. This checks that sectors skipped by the erase stay readable and programmable.

// File: rtl/flash_sector_guard.sv
module flash_sector_guard #(
  parameter bit TOP_BOOT = 1'b0,
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic          prot_we,
  input  logic [3:0]    prot_idx,
  input  logic          prot_val,
  input  logic          sel_we,
  input  logic [3:0]    sel_idx,
  input  logic          sel_val,
  input  logic          tmp_unprot,
  input  logic          erase_susp,
  input  logic          erase_done,
  output logic [3:0]    sec_idx,
  output logic          permit,
  output logic          reject,
  output logic [10:0]   erase_set
);
  localparam int NSEC = 11;
  localparam logic [1:0] OP_RD = 2'd0, OP_PG = 2'd1, OP_SE = 2'd2, OP_CE = 2'd3;

  logic [NSEC-1:0] prot_q, sel_q, pend_q;
  logic [NSEC-1:0] eff_prot, cur_bit, er_cand;
  logic [3:0]      cur_sec;
  logic            busy, in_pend, is_erase, ok;

  function automatic logic [3:0] bot_idx(input logic [AW-1:0] a);
    if (a[AW-1:AW-3] != 3'd0) return 4'(a[AW-1:AW-3]) + 4'd3;
    else if (a[AW-4])         return 4'd3;
    else if (a[AW-5])         return a[AW-6] ? 4'd2 : 4'd1;
    else                      return 4'd0;
  endfunction

  generate
    if (TOP_BOOT) begin : g_top
      assign cur_sec = 4'd10 - bot_idx(~req_addr);
    end else begin : g_bot
      assign cur_sec = bot_idx(req_addr);
    end
  endgenerate

  assign eff_prot = tmp_unprot ? '0 : prot_q;
  assign cur_bit  = NSEC'(1) << cur_sec;
  assign busy     = (pend_q != '0) && !erase_susp;
  assign in_pend  = erase_susp && ((pend_q & cur_bit) != '0);
  assign is_erase = (req_op == OP_SE) || (req_op == OP_CE);
  assign er_cand  = ((req_op == OP_CE) ? {NSEC{1'b1}} : sel_q) & ~eff_prot;

  always_comb begin
    case (req_op)
      OP_RD:   ok = !busy && !in_pend;
      OP_PG:   ok = !busy && !in_pend && ((eff_prot & cur_bit) == '0);
      default: ok = (pend_q == '0) && (er_cand != '0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q    <= '0;
      sel_q     <= '0;
      pend_q    <= '0;
      sec_idx   <= '0;
      permit    <= 1'b0;
      reject    <= 1'b0;
      erase_set <= '0;
    end else begin
      permit    <= req_valid && ok;
      reject    <= req_valid && !ok;
      erase_set <= (req_valid && is_erase && ok) ? er_cand : '0;
      if (req_valid) sec_idx <= cur_sec;
      if (prot_we && prot_idx < 4'(NSEC)) prot_q[prot_idx] <= prot_val;
      if (req_valid && is_erase && ok)     sel_q <= '0;
      else if (sel_we && sel_idx < 4'(NSEC)) sel_q[sel_idx] <= sel_val;
      if (req_valid && is_erase && ok) pend_q <= er_cand;
      else if (erase_done)             pend_q <= '0;
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(permit && reject)); // R8
  AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (permit || reject)); // R8
  AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!permit && !reject)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (permit || reject) |-> (sec_idx < 4'(NSEC))); // R1
  AST_ESET_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!tmp_unprot) && erase_set != '0) |-> ((erase_set & $past(prot_q)) == '0)); // R4
  AST_PROT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_PG && !tmp_unprot && (prot_q & cur_bit) != '0) |=> reject); // R3
  AST_SUSP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_erase && erase_susp && (pend_q & cur_bit) != '0) |=> reject); // R7
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0 && !erase_done) |=> (pend_q == $past(pend_q))); // R11
  AST_TMP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tmp_unprot && !prot_we) |=> (prot_q == $past(prot_q))); // R5
endmodule

// File: tb/flash_sector_guard_bench.sv
module flash_sector_guard_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, prot_we = 0, prot_val = 0, sel_we = 0, sel_val = 0;
  logic tmp_unprot = 0, erase_susp = 0, erase_done = 0;
  logic [1:0] req_op = 0;
  logic [18:0] req_addr = 0;
  logic [3:0] prot_idx = 0, sel_idx = 0;
  logic [3:0] sec_idx, t_sec;
  logic permit, reject, t_permit, t_reject;
  logic [10:0] erase_set, t_eset;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  flash_sector_guard #(.TOP_BOOT(1'b0)) u_flash_sector_guard (
    .clk, .rst_n, .req_valid, .req_op, .req_addr, .prot_we, .prot_idx, .prot_val,
    .sel_we, .sel_idx, .sel_val, .tmp_unprot, .erase_susp, .erase_done,
    .sec_idx, .permit, .reject, .erase_set);

  flash_sector_guard #(.TOP_BOOT(1'b1)) u_flash_sector_guard_top (
    .clk, .rst_n, .req_valid, .req_op, .req_addr, .prot_we, .prot_idx, .prot_val,
    .sel_we, .sel_idx, .sel_val, .tmp_unprot, .erase_susp, .erase_done,
    .sec_idx(t_sec), .permit(t_permit), .reject(t_reject), .erase_set(t_eset));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_bot(input int a);
    if (a < 'h4000) return 0;
    if (a < 'h6000) return 1;
    if (a < 'h8000) return 2;
    if (a < 'h10000) return 3;
    return 3 + a / 'h10000;
  endfunction

  function automatic int exp_top(input int a);
    if (a < 'h70000) return a / 'h10000;
    if (a < 'h78000) return 7;
    if (a < 'h7A000) return 8;
    if (a < 'h7C000) return 9;
    return 10;
  endfunction

  task automatic do_req(input logic [1:0] op, input int a);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = 19'(a);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wr_prot(input int idx, input bit v);
    @(negedge clk);
    prot_we = 1; prot_idx = 4'(idx); prot_val = v;
    @(negedge clk);
    prot_we = 0;
  endtask

  task automatic wr_sel(input int idx);
    @(negedge clk);
    sel_we = 1; sel_idx = 4'(idx); sel_val = 1;
    @(negedge clk);
    sel_we = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    erase_done = 1;
    @(negedge clk);
    erase_done = 0;
  endtask

  task automatic t_reset();
    chk(!permit && !reject && erase_set == 0, "R9 outputs idle", {permit, reject}, 0);
    do_req(1, 'h3FFF);
    chk(permit && !reject, "R9 protect clear after reset", permit, 1);
    do_req(2, 0);
    chk(reject, "R9 selection mask empty after reset", reject, 1);
    do_req(0, 'h50000);
    chk(permit, "R9 no pending erase after reset", permit, 1);
  endtask

  task automatic t_map();
    int addrs[18] = '{'h0, 'h3FFF, 'h4000, 'h5FFF, 'h6000, 'h7FFF, 'h8000, 'hFFFF, 'h10000,
                      'h6FFFF, 'h70000, 'h77FFF, 'h78000, 'h79FFF, 'h7A000, 'h7BFFF, 'h7C000, 'h7FFFF};
    for (int i = 0; i < 18; i++) begin
      do_req(0, addrs[i]);
      chk(sec_idx == 4'(exp_bot(addrs[i])) && permit, "R1 bottom map", sec_idx, exp_bot(addrs[i]));
      chk(t_sec == 4'(exp_top(addrs[i])) && t_permit, "R2 top map", t_sec, exp_top(addrs[i]));
    end
  endtask

  task automatic t_protect();
    wr_prot(4, 1);
    do_req(1, 'h1ABCD);
    chk(reject && !permit, "R3 program to protected sector", reject, 1);
    chk(sec_idx == 4, "R8 index on reject", sec_idx, 4);
    do_req(1, 'h20000);
    chk(permit, "R3 program to open sector", permit, 1);
    wr_sel(4); wr_sel(5);
    do_req(2, 0);
    chk(permit && erase_set == 11'h020, "R4 protected sector dropped", erase_set, 'h20);
    @(negedge clk);
    chk(!permit && !reject && erase_set == 0, "R8 single-cycle pulse", {permit, reject}, 0);
    pulse_done();
    do_req(2, 0);
    chk(reject && erase_set == 0, "R12 mask cleared by accepted erase", reject, 1);
    wr_sel(4);
    do_req(2, 0);
    chk(reject, "R4 only protected sectors selected", reject, 1);
  endtask

  task automatic t_tmp();
    @(negedge clk); tmp_unprot = 1;
    do_req(1, 'h1ABCD);
    chk(permit, "R5 override lifts protection", permit, 1);
    @(negedge clk); tmp_unprot = 0;
    do_req(1, 'h1ABCD);
    chk(reject, "R5 protection back after release", reject, 1);
  endtask

  task automatic t_chip();
    wr_prot(0, 1); wr_prot(10, 1);
    do_req(3, 'h12345);
    chk(permit && erase_set == 11'h3EE, "R6 chip erase skips protected", erase_set, 'h3EE);
    do_req(1, 'h50000);
    chk(reject, "R7 program during running erase", reject, 1);
    do_req(2, 0);
    chk(reject, "R11 erase while pending", reject, 1);
    @(negedge clk); erase_susp = 1;
    do_req(1, 'h4000);
    chk(reject, "R7 program into pending sector", reject, 1);
    do_req(0, 'h4000);
    chk(reject, "R7 read of pending sector", reject, 1);
    do_req(0, 'h0);
    chk(permit, "R7 read outside pending set", permit, 1);
    do_req(0, 'h10000);
    chk(permit, "R7 read of skipped protected sector", permit, 1);
    do_req(1, 'h0);
    chk(reject, "R3 protect still applies in suspend", reject, 1);
    @(negedge clk); erase_susp = 0;
    pulse_done();
    do_req(1, 'h4000);
    chk(permit, "R11 done clears pending set", permit, 1);
  endtask

  task automatic t_collide();
    @(negedge clk);
    prot_we = 1; prot_idx = 2; prot_val = 1;
    req_valid = 1; req_op = 1; req_addr = 19'h6000;
    @(negedge clk);
    prot_we = 0; req_valid = 0;
    chk(permit, "R10 set and program same cycle uses old bit", permit, 1);
    do_req(1, 'h6000);
    chk(reject, "R10 next request sees new bit", reject, 1);
    @(negedge clk);
    prot_we = 1; prot_idx = 2; prot_val = 0;
    req_valid = 1; req_op = 1; req_addr = 19'h7FFF;
    @(negedge clk);
    prot_we = 0; req_valid = 0;
    chk(reject, "R10 clear and program same cycle uses old bit", reject, 1);
    do_req(1, 'h7FFF);
    chk(permit, "R10 next request after clear", permit, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_map();
    t_protect();
    t_tmp();
    t_chip();
    t_collide();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule